// File: doc/BRIEF.md
# Ethernet Slot-Time Tick Generator

This block measures slot times for the transmit side of a half-duplex Ethernet MAC. A bit-rate clock enable paces it. Each time one full slot of bit times has elapsed, it emits a single-cycle tick. The slot length comes from a two-bit select field. The counter samples that field only when a run begins and at each slot boundary, so a slot already in progress always completes at the length it started with.

The timer has two arming modes. In transmit mode, a rising edge on carrier sense starts the count; that edge marks the start of a returning preamble. In backoff mode, the falling edge of transmit enable starts the count; that edge marks the end of the collided frame. In backoff mode, carrier activity on the wire has no effect on the timer. After it starts, the timer runs free and ticks once per slot until an explicit stop clears it. Random draws and the retry decision are made elsewhere; they only consume the ticks.

Top module: `slot_timer`

## Requirements
- R1: The select field encodes the slot length as follows: 2'b01 gives 256 bit times, 2'b00 gives 512, 2'b10 gives 1024, and the spare code 2'b11 also gives 512.
- R2: After reset, `running` and `slot_tick` are low, and the reset value of the select field (2'b00) gives 512 bit times.
- R3: In transmit mode (`mode`=0), a clock edge that sees `carrier` high after it was low on the previous edge starts a run from zero while the timer is idle. The first `slot_tick` is high in the cycle that follows the edge taking the slot-length-th `bit_en` pulse after the start edge.
- R4: In backoff mode (`mode`=1), a clock edge that sees `tx_en` low after it was high on the previous edge starts a run from zero while the timer is idle, with the same tick timing as R3.
- R5: In backoff mode, carrier rising or falling while the timer runs does not restart, stop or shift the count.
- R6: A `tx_en` falling edge does not start the timer in transmit mode. A `carrier` rising edge does not start it in backoff mode.
- R7: `slot_tick` lasts exactly one cycle. The count then wraps to zero, and the timer keeps ticking once per slot while it runs.
- R8: A change of the select field during a slot takes effect only from the next slot boundary.
- R9: `stop` clears the count and drops `running` on the next edge. It takes priority over a start trigger on the same edge.
- R10: The count advances only on edges where `bit_en` is high. Cycles without it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per bit time |
| mode | input | 1 | 0 = transmit arming, 1 = backoff arming |
| carrier | input | 1 | Carrier sense from the medium |
| tx_en | input | 1 | Transmit enable of the local frame |
| slot_sel | input | 2 | Slot-length select code |
| stop | input | 1 | Clears the count and ends the run |
| slot_tick | output | 1 | One-cycle pulse at each slot boundary |
| running | output | 1 | Timer is armed and counting |

## Verification
A count that is off by any amount shows up at the ports as a first tick early or late by that number of `bit_en` pulses. The error is visible within one slot of the fault. A latched length that was reloaded mid-slot moves the very next tick, while a missed reload shifts the second tick. A start latch that reacts to the wrong edge or mode raises `running` within one cycle of the stray edge. A counter that carrier disturbs in backoff mode moves the tick that follows the disturbance.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;

  typedef enum logic [1:0] {
    SEL_512  = 2'b00,
    SEL_256  = 2'b01,
    SEL_1024 = 2'b10,
    SEL_SPARE = 2'b11
  } slot_sel_e;

  typedef enum logic {
    MODE_XMIT    = 1'b0,
    MODE_BACKOFF = 1'b1
  } arm_mode_e;

  // Slot length in bit times for a select code; base is the shortest slot.
  function automatic int unsigned slot_bits(input logic [1:0] sel,
                                            input int unsigned base);
    case (sel)
      SEL_256:  slot_bits = base;
      SEL_1024: slot_bits = base * 4;
      default:  slot_bits = base * 2;
    endcase
  endfunction

endpackage

// File: rtl/slot_start_detect.sv
module slot_start_detect
  import slot_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic carrier,
  input  logic tx_en,
  input  logic running,
  output logic start_xmit,
  output logic start_backoff,
  output logic start
);

  logic carrier_q;
  logic tx_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_q <= 1'b0;
      tx_en_q   <= 1'b0;
    end else begin
      carrier_q <= carrier;
      tx_en_q   <= tx_en;
    end
  end

  // Each mode listens to its own edge only; the other input is ignored.
  assign start_xmit    = (mode == MODE_XMIT)    && !running && carrier && !carrier_q;
  assign start_backoff = (mode == MODE_BACKOFF) && !running && !tx_en && tx_en_q;
  assign start         = start_xmit || start_backoff;

  p_single_trigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_xmit, start_backoff}));

  p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !start);

endmodule

// File: rtl/slot_len_reg.sv
module slot_len_reg
  import slot_timer_pkg::*;
#(
  parameter int unsigned BASE_BITS = 256,
  localparam int unsigned LW = $clog2(4 * BASE_BITS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    slot_sel,
  input  logic          load,
  output logic [LW-1:0] len
);

  logic [LW-1:0] len_next;

  assign len_next = LW'(slot_bits(slot_sel, BASE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len <= LW'(slot_bits(SEL_512, BASE_BITS));
    else if (load) len <= len_next;
  end

endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int unsigned BASE_BITS = 256,
  localparam int unsigned LW = $clog2(4 * BASE_BITS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          start,
  input  logic          stop,
  input  logic [LW-1:0] len,
  output logic          running,
  output logic          boundary,
  output logic          slot_tick
);

  logic [LW-1:0] cnt;

  assign boundary = running && bit_en && !stop && (cnt == len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt       <= '0;
      slot_tick <= 1'b0;
    end else begin
      slot_tick <= boundary;
      if (stop) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running && bit_en) begin
        cnt <= boundary ? '0 : cnt + LW'(1);
      end
    end
  end

  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < len));

  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> !slot_tick);

  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |-> running);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && cnt == '0 && !slot_tick));

  p_hold_without_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !bit_en && !stop) |=> (running && $stable(cnt)));

endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_timer_pkg::*;
#(
  parameter int unsigned BASE_BITS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       mode,
  input  logic       carrier,
  input  logic       tx_en,
  input  logic [1:0] slot_sel,
  input  logic       stop,
  output logic       slot_tick,
  output logic       running
);

  localparam int unsigned LW = $clog2(4 * BASE_BITS) + 1;

  logic          start_xmit;
  logic          start_backoff;
  logic          start;
  logic          boundary;
  logic          len_load;
  logic [LW-1:0] len;

  slot_start_detect u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .carrier       (carrier),
    .tx_en         (tx_en),
    .running       (running),
    .start_xmit    (start_xmit),
    .start_backoff (start_backoff),
    .start         (start)
  );

  // Length is sampled only when a run begins or a slot wraps.
  assign len_load = (start && !stop) || boundary;

  slot_len_reg #(.BASE_BITS(BASE_BITS)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_sel (slot_sel),
    .load     (len_load),
    .len      (len)
  );

  slot_counter #(.BASE_BITS(BASE_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .start     (start),
    .stop      (stop),
    .len       (len),
    .running   (running),
    .boundary  (boundary),
    .slot_tick (slot_tick)
  );

  p_len_hold_mid_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !boundary && !stop) |=> $stable(len));

  p_backoff_keeps_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BACKOFF && running && !stop) |=> running);

endmodule

// File: tb/slot_timer_bench.sv
module slot_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       mode = 1'b0;
  logic       carrier = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] slot_sel = 2'b00;
  logic       stop = 1'b0;
  logic       slot_tick;
  logic       running;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slot_timer u_slot_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
    .carrier(carrier), .tx_en(tx_en), .slot_sel(slot_sel),
    .stop(stop), .slot_tick(slot_tick), .running(running)
  );

  typedef struct packed {
    logic       md;
    logic [1:0] sel;
    logic [7:0] per;
    logic [15:0] exp_bits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 2'b00, 8'd1, 16'd512},
    '{1'b0, 2'b01, 8'd1, 16'd256},
    '{1'b0, 2'b10, 8'd1, 16'd1024},
    '{1'b1, 2'b11, 8'd1, 16'd512},
    '{1'b1, 2'b01, 8'd3, 16'd256},
    '{1'b0, 2'b01, 8'd2, 16'd256},
    '{1'b1, 2'b00, 8'd1, 16'd512}
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic en);
    bit_en = en;
    @(posedge clk);
    #1;
  endtask

  // Counts bit_en pulses until slot_tick is seen; -1 if none within lim cycles.
  task automatic count_to_tick(input int per, input int lim, output int n);
    int pulses = 0;
    n = -1;
    for (int k = 0; k < lim; k++) begin
      step(k % per == 0);
      if (k % per == 0) pulses++;
      if (slot_tick) begin
        n = pulses;
        break;
      end
    end
  endtask

  task automatic go_idle();
    stop = 1'b1; step(0);
    stop = 1'b0; carrier = 1'b0; tx_en = 1'b0;
    step(0);
  endtask

  task automatic arm(input logic md);
    mode = md;
    if (md == 1'b0) begin
      carrier = 1'b0; step(0);
      carrier = 1'b1; step(0);
    end else begin
      tx_en = 1'b1; step(0);
      tx_en = 1'b0; step(0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(running, 0, "R2 running low in reset");
    rst_n = 1'b1;
    step(0);
    chk(running, 0, "R2 running low after reset");
    chk(slot_tick, 0, "R2 tick low after reset");

    // Table walk: R1 lengths, R3/R4 start edges, R10 paced counting.
    foreach (VECS[i]) begin
      go_idle();
      slot_sel = VECS[i].sel;
      arm(VECS[i].md);
      chk(running, 1, VECS[i].md ? "R4 armed on tx_en fall" : "R3 armed on carrier rise");
      count_to_tick(int'(VECS[i].per), int'(VECS[i].exp_bits) * int'(VECS[i].per) + 20, n);
      chk(n, int'(VECS[i].exp_bits), "R1 first tick after slot length");
    end

    // R7: single-cycle tick and periodic wrap.
    step(1);
    chk(slot_tick, 0, "R7 tick lasts one cycle");
    count_to_tick(1, 600, n);
    chk(n, 511, "R7 second tick one slot later");

    // R8: select change mid-slot waits for the boundary.
    go_idle();
    slot_sel = 2'b01;
    arm(1'b0);
    slot_sel = 2'b10;
    count_to_tick(1, 1200, n);
    chk(n, 256, "R8 current slot keeps old length");
    count_to_tick(1, 1200, n);
    chk(n, 1024, "R8 next slot uses new length");

    // R5: carrier activity during backoff neither restarts nor shifts.
    go_idle();
    slot_sel = 2'b01;
    arm(1'b1);
    for (int k = 0; k < 50; k++) step(1);
    carrier = 1'b1;
    for (int k = 0; k < 10; k++) step(1);
    carrier = 1'b0;
    chk(running, 1, "R5 still running under carrier");
    count_to_tick(1, 400, n);
    chk(n, 196, "R5 tick unshifted by carrier");

    // R6: wrong-mode edges do not arm.
    go_idle();
    mode = 1'b0;
    tx_en = 1'b1; step(0);
    tx_en = 1'b0; step(0); step(0);
    chk(running, 0, "R6 tx_en fall ignored in transmit mode");
    mode = 1'b1;
    carrier = 1'b0; step(0);
    carrier = 1'b1; step(0); step(0);
    chk(running, 0, "R6 carrier rise ignored in backoff mode");
    carrier = 1'b0;

    // R9: stop clears; stop beats a simultaneous start.
    go_idle();
    slot_sel = 2'b01;
    arm(1'b1);
    for (int k = 0; k < 100; k++) step(1);
    stop = 1'b1; step(1);
    stop = 1'b0;
    chk(running, 0, "R9 stop drops running");
    chk(slot_tick, 0, "R9 no tick after stop");
    tx_en = 1'b1; step(0);
    tx_en = 1'b0; stop = 1'b1; step(0);
    stop = 1'b0; step(0);
    chk(running, 0, "R9 stop wins over start");
    arm(1'b1);
    count_to_tick(1, 400, n);
    chk(n, 256, "R9 count restarts from zero");

    // R10: no bit_en, no progress.
    go_idle();
    slot_sel = 2'b01;
    arm(1'b0);
    n = 0;
    for (int k = 0; k < 600; k++) begin
      step(0);
      if (slot_tick) n++;
    end
    chk(n, 0, "R10 no tick without bit_en");
    chk(running, 1, "R10 still running while paused");
    count_to_tick(1, 400, n);
    chk(n, 256, "R10 count resumes intact");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule